// File: doc/BRIEF.md
# PHY Management Register Responder

This block answers management-register commands on the MAC side of a link as if an attached PHY were present. Software writes a command word that names a PHY address, a register index and a direction. When the address matches the strapped PHY address, one of six standard PHY registers is read into the data register or written from it. Control and advertisement are the only storage. Identifier, status and partner-ability values are fixed, apart from one status bit that tracks a link input.

Writes enter through a valid/ready port. A command write is accepted only while `wr_ready` is high. `wr_ready` then drops for exactly one cycle while the command executes. During that cycle any write is held off: the source must keep `wr_valid` and its payload until `wr_ready` returns. Reads are combinational on `rd_sel`: 0 selects the command word and 1 selects the data word.

Top module: `phy_mgmt_responder`

## Requirements
- R1: A command write stores the 32-bit word with bit 0 (busy) forced to zero. Reading the command word returns it that way. In the command word, bits 15:12 are the PHY address, bits 7:4 the register index, and bit 1 set means write.
- R2: A command whose address field differs from `phy_addr` leaves the data word and every PHY register unchanged.
- R3: A write to index 0 (control) with bit 15 clear stores the low 16 data bits with bits 15 and 9 cleared.
- R4: A write to index 0 with bit 15 set restores control to 0x3100 and advertisement to 0, and keeps the link bit.
- R5: After reset, the command and data words read 0, control reads 0x3100, advertisement reads 0, and `wr_ready` is high.
- R6: Index 1 (status) reads 0xFE28, OR 0x0004 when the synchronised link input is high.
- R7: Index 2 reads 0x0044 and index 3 reads 0x1400. Writes to either have no effect.
- R8: Index 5 (partner ability) reads 0x0DE0.
- R9: Index 4 (advertisement) stores all 16 low data bits and reads them back.
- R10: A read of an index above 5 returns 0. A write to an index other than 0 or 4 has no effect.
- R11: On the clock edge after a command is accepted, a read command's result is in the data word. `wr_ready` is low for exactly that one cycle.
- R12: A write presented while `wr_ready` is low is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write can be accepted this cycle |
| wr_sel | input | 1 | Write target: 0 command, 1 data |
| wr_data | input | 32 | Write payload |
| rd_sel | input | 1 | Read source: 0 command, 1 data |
| rd_data | output | 32 | Selected word |
| phy_addr | input | 4 | Strapped PHY address |
| link_up | input | 1 | Link status from the line side |

## Verification
A wrong control or advertisement value stays hidden until software reads that index. It then appears in the data word one edge after the read command. For this reason every write in the bench is followed by a read of the same index. A stuck pending flag appears at once as `wr_ready` held low. An address-match fault appears on the first foreign-address command as a changed data word. A bad link path appears in status bit 2 a few cycles after the input changes.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;
  localparam int unsigned PHY_REG_W = 16;
  localparam int unsigned PADDR_W   = 4;
  localparam int unsigned IDX_W     = 4;

  // command word field positions
  localparam int unsigned PADDR_LSB = 12;
  localparam int unsigned IDX_LSB   = 4;
  localparam int unsigned DIR_BIT   = 1;
  localparam int unsigned BUSY_BIT  = 0;

  // register indices
  localparam logic [IDX_W-1:0] IDX_CTRL = 4'd0;
  localparam logic [IDX_W-1:0] IDX_STAT = 4'd1;
  localparam logic [IDX_W-1:0] IDX_IDH  = 4'd2;
  localparam logic [IDX_W-1:0] IDX_IDL  = 4'd3;
  localparam logic [IDX_W-1:0] IDX_ADV  = 4'd4;
  localparam logic [IDX_W-1:0] IDX_LPA  = 4'd5;

  // fixed values and defaults
  localparam logic [PHY_REG_W-1:0] CTRL_DEFAULT = 16'h3100;
  localparam logic [PHY_REG_W-1:0] CTRL_WMASK   = 16'h8200; // self-clearing bits
  localparam int unsigned          CTRL_RST_BIT = 15;
  localparam logic [PHY_REG_W-1:0] STAT_BASE    = 16'hFE28;
  localparam int unsigned          STAT_LINK    = 2;
  localparam logic [PHY_REG_W-1:0] ID_HIGH      = 16'h0044;
  localparam logic [PHY_REG_W-1:0] ID_LOW       = 16'h1400;
  localparam logic [PHY_REG_W-1:0] LPA_VALUE    = 16'h0DE0;

  typedef enum logic {SEL_CMD = 1'b0, SEL_DATA = 1'b1} word_sel_e;
endpackage

// File: rtl/mgmt_link_sync.sv
module mgmt_link_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic link_in,
  output logic link_out
);
  generate
    if (STAGES == 0) begin : g_pass
      assign link_out = link_in;
    end else begin : g_chain
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else if (STAGES == 1) chain_q <= link_in;
        else chain_q <= {chain_q[STAGES-2:0], link_in};
      end
      assign link_out = chain_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/mgmt_phy_regs.sv
module mgmt_phy_regs
  import phy_mgmt_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 exec_en,
  input  logic                 exec_write,
  input  logic [IDX_W-1:0]     exec_idx,
  input  logic [PHY_REG_W-1:0] exec_wdata,
  input  logic                 link_in,
  output logic [PHY_REG_W-1:0] exec_rdata
);
  logic [PHY_REG_W-1:0] ctrl_q;
  logic [PHY_REG_W-1:0] adv_q;
  logic                 wr_ctrl, wr_adv, soft_rst;

  assign wr_ctrl  = exec_en && exec_write && (exec_idx == IDX_CTRL);
  assign wr_adv   = exec_en && exec_write && (exec_idx == IDX_ADV);
  assign soft_rst = wr_ctrl && exec_wdata[CTRL_RST_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n || soft_rst) begin
      ctrl_q <= CTRL_DEFAULT;
      adv_q  <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= exec_wdata & ~CTRL_WMASK;
      if (wr_adv)  adv_q  <= exec_wdata;
    end
  end

  always_comb begin
    unique case (exec_idx)
      IDX_CTRL: exec_rdata = ctrl_q;
      IDX_STAT: begin
        exec_rdata = STAT_BASE;
        exec_rdata[STAT_LINK] = link_in;
      end
      IDX_IDH:  exec_rdata = ID_HIGH;
      IDX_IDL:  exec_rdata = ID_LOW;
      IDX_ADV:  exec_rdata = adv_q;
      IDX_LPA:  exec_rdata = LPA_VALUE;
      default:  exec_rdata = '0;
    endcase
  end

  // R3: stored control never holds a self-clearing bit
  p_ctrl_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[15] && !ctrl_q[9]);

  // R4: soft reset lands defaults on the next edge
  p_soft_reset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (ctrl_q == CTRL_DEFAULT) && (adv_q == '0));

  // R7: identifier and partner writes leave control and advertisement alone
  p_ro_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && exec_write && (exec_idx == IDX_IDH || exec_idx == IDX_IDL || exec_idx == IDX_LPA))
    |=> $stable(ctrl_q) && $stable(adv_q));
endmodule

// File: rtl/phy_mgmt_responder.sv
module phy_mgmt_responder
  import phy_mgmt_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned LINK_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_sel,
  output logic [DATA_W-1:0] rd_data,
  input  logic [PADDR_W-1:0] phy_addr,
  input  logic              link_up
);
  localparam int unsigned PAD_W = DATA_W - PHY_REG_W;

  logic [DATA_W-1:0]    cmd_q, data_q;
  logic                 pending_q;
  logic                 link_s;
  logic                 take_cmd, take_data, addr_hit, exec_en, exec_write;
  logic [IDX_W-1:0]     exec_idx;
  logic [PHY_REG_W-1:0] exec_rdata;

  assign wr_ready   = !pending_q;
  assign take_cmd   = wr_valid && wr_ready && (wr_sel == SEL_CMD);
  assign take_data  = wr_valid && wr_ready && (wr_sel == SEL_DATA);
  assign addr_hit   = (cmd_q[PADDR_LSB +: PADDR_W] == phy_addr);
  assign exec_en    = pending_q && addr_hit;
  assign exec_write = cmd_q[DIR_BIT];
  assign exec_idx   = cmd_q[IDX_LSB +: IDX_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q     <= '0;
      data_q    <= '0;
      pending_q <= 1'b0;
    end else begin
      pending_q <= take_cmd;
      if (take_cmd) begin
        cmd_q           <= wr_data;
        cmd_q[BUSY_BIT] <= 1'b0;
      end
      if (take_data) data_q <= wr_data;
      else if (exec_en && !exec_write) data_q <= {{PAD_W{1'b0}}, exec_rdata};
    end
  end

  assign rd_data = (rd_sel == SEL_DATA) ? data_q : cmd_q;

  mgmt_link_sync #(.STAGES(LINK_STAGES)) u_link (
    .clk(clk), .rst_n(rst_n), .link_in(link_up), .link_out(link_s)
  );

  mgmt_phy_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .exec_en(exec_en), .exec_write(exec_write), .exec_idx(exec_idx),
    .exec_wdata(data_q[PHY_REG_W-1:0]), .link_in(link_s),
    .exec_rdata(exec_rdata)
  );

  // R11: ready drops for the cycle after a command is taken
  p_ready_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    take_cmd |=> !wr_ready);

  // R11: ready always returns after one busy cycle
  p_ready_return_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ready |=> wr_ready);

  // R2: foreign-address command leaves the data word untouched
  p_foreign_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_q && !addr_hit) |=> $stable(data_q));

  // R9: a write command never alters the data word
  p_write_keeps_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_q && exec_write) |=> $stable(data_q));

  // R6: status read carries the synchronised link level
  p_link_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && !exec_write && exec_idx == IDX_STAT) |=> data_q[STAT_LINK] == $past(link_s));

  // R1: busy bit never reads back set
  p_busy_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(take_cmd) |-> !cmd_q[BUSY_BIT]);
endmodule

// File: tb/tb_phy_mgmt_responder.sv
module tb_phy_mgmt_responder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic        wr_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_sel = 1'b1;
  logic [31:0] rd_data;
  logic [3:0]  phy_addr = 4'd5;
  logic        link_up = 1'b1;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  phy_mgmt_responder dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .phy_addr(phy_addr), .link_up(link_up)
  );

  function automatic logic [15:0] mk_cmd(input logic [3:0] a, input logic [3:0] idx, input logic w);
    return {a, 4'h0, idx, 2'b00, w, 1'b0};
  endfunction

  // {req[52:49], has_pre[48], pre[47:32], cmd[31:16], exp[15:0]}
  function automatic logic [52:0] mkv(input logic [3:0] rq, input logic hp, input logic [15:0] pre,
                                      input logic [15:0] cmd, input logic [15:0] ex);
    return {rq, hp, pre, cmd, ex};
  endfunction

  localparam int NV = 19;
  localparam logic [52:0] VEC [NV] = '{
    mkv(4'd5,  1'b0, 16'h0000, mk_cmd(4'd5, 4'd0, 1'b0), 16'h3100), // R5 control default
    mkv(4'd6,  1'b0, 16'h0000, mk_cmd(4'd5, 4'd1, 1'b0), 16'hFE2C), // R6 status, link up
    mkv(4'd7,  1'b0, 16'h0000, mk_cmd(4'd5, 4'd2, 1'b0), 16'h0044), // R7
    mkv(4'd7,  1'b0, 16'h0000, mk_cmd(4'd5, 4'd3, 1'b0), 16'h1400), // R7
    mkv(4'd8,  1'b0, 16'h0000, mk_cmd(4'd5, 4'd5, 1'b0), 16'h0DE0), // R8
    mkv(4'd5,  1'b0, 16'h0000, mk_cmd(4'd5, 4'd4, 1'b0), 16'h0000), // R5 adv default
    mkv(4'd9,  1'b1, 16'hA5E1, mk_cmd(4'd5, 4'd4, 1'b1), 16'hA5E1), // R9 write adv
    mkv(4'd9,  1'b0, 16'h0000, mk_cmd(4'd5, 4'd4, 1'b0), 16'hA5E1), // R9 readback
    mkv(4'd7,  1'b1, 16'hFFFF, mk_cmd(4'd5, 4'd2, 1'b1), 16'hFFFF), // R7 write id
    mkv(4'd7,  1'b0, 16'h0000, mk_cmd(4'd5, 4'd2, 1'b0), 16'h0044), // R7 id unchanged
    mkv(4'd10, 1'b0, 16'h0000, mk_cmd(4'd5, 4'd6, 1'b0), 16'h0000), // R10
    mkv(4'd10, 1'b0, 16'h0000, mk_cmd(4'd5, 4'd15, 1'b0), 16'h0000), // R10
    mkv(4'd3,  1'b1, 16'h2300, mk_cmd(4'd5, 4'd0, 1'b1), 16'h2300), // R3 write ctrl
    mkv(4'd3,  1'b0, 16'h0000, mk_cmd(4'd5, 4'd0, 1'b0), 16'h2100), // R3 bit 9 cleared
    mkv(4'd2,  1'b1, 16'h1234, mk_cmd(4'd3, 4'd0, 1'b0), 16'h1234), // R2 foreign read
    mkv(4'd2,  1'b1, 16'h0BAD, mk_cmd(4'd4, 4'd4, 1'b1), 16'h0BAD), // R2 foreign write
    mkv(4'd2,  1'b0, 16'h0000, mk_cmd(4'd5, 4'd4, 1'b0), 16'hA5E1), // R2 adv kept
    mkv(4'd4,  1'b1, 16'h8000, mk_cmd(4'd5, 4'd0, 1'b1), 16'h8000), // R4 soft reset
    mkv(4'd4,  1'b0, 16'h0000, mk_cmd(4'd5, 4'd0, 1'b0), 16'h3100)  // R4 ctrl default
  };

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [31:0] v);
    @(negedge clk);
    while (!wr_ready) @(negedge clk);
    wr_valid = 1'b1; wr_sel = sel; wr_data = v;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  // command then wait for the execution edge
  task automatic run_cmd(input logic [31:0] c);
    wr(1'b0, c);
    @(negedge clk);
  endtask

  initial begin
    #(8 * 20000);
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd_sel = 1'b0; #1 check("R5 cmd reset", rd_data, 32'h0);
    rd_sel = 1'b1; #1 check("R5 data reset", rd_data, 32'h0);
    check("R5 ready reset", {31'b0, wr_ready}, 32'h1);

    for (int i = 0; i < NV; i++) begin
      logic [52:0] v;
      v = VEC[i];
      if (v[48]) wr(1'b1, {16'h0, v[47:32]});
      run_cmd({16'h0, v[31:16]});
      rd_sel = 1'b1; #1
      check($sformatf("R%0d vec %0d", v[52:49], i), rd_data, {16'h0, v[15:0]});
    end

    // R4: soft reset also restored advertisement
    run_cmd({16'h0, mk_cmd(4'd5, 4'd4, 1'b0)});
    check("R4 adv cleared", rd_data, 32'h0);

    // R1: busy bit dropped, other bits kept
    wr(1'b0, 32'hABC0_5023);
    rd_sel = 1'b0; #1 check("R1 busy cleared", rd_data, 32'hABC0_5022);
    // R11: ready low right after acceptance
    check("R11 ready low", {31'b0, wr_ready}, 32'h0);
    @(negedge clk);
    check("R11 ready back", {31'b0, wr_ready}, 32'h1);

    // R11 + R12: write during busy cycle is not taken
    wr(1'b0, {16'h0, mk_cmd(4'd5, 4'd3, 1'b0)});
    wr_valid = 1'b1; wr_sel = 1'b1; wr_data = 32'hDEAD_BEEF;
    @(negedge clk);
    wr_valid = 1'b0;
    rd_sel = 1'b1; #1 check("R12 stalled write dropped", rd_data, 32'h0000_1400);

    // R6: link down seen in status
    link_up = 1'b0;
    repeat (4) @(negedge clk);
    run_cmd({16'h0, mk_cmd(4'd5, 4'd1, 1'b0)});
    check("R6 status link down", rd_data, 32'h0000_FE28);

    // R4: soft reset keeps link state
    wr(1'b1, 32'h0000_8000);
    run_cmd({16'h0, mk_cmd(4'd5, 4'd0, 1'b1)});
    run_cmd({16'h0, mk_cmd(4'd5, 4'd1, 1'b0)});
    check("R4 link kept", rd_data, 32'h0000_FE28);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule